// File: doc/BRIEF.md
# I2C Target Front End with Selectable and All-Call Addressing

This block is the serial front end of a small register-mapped peripheral on an I2C bus. It oversamples SCL and SDA with the system clock and finds START, repeated START and STOP conditions. It then decodes the address byte and hands the transferred bytes to a register bank through a simple strobe-and-request port. SDA is never driven high. The block only pulls the line low through an output-enable, and the pad and the bus pull-up do the rest.

Each device answers two addresses. Its individual address is one of two values, chosen by a strap input, so two devices can share one bus. It also answers a broadcast address common to every device, so one write can program several devices at once. The broadcast address takes writes only.

In a write, the byte after the address sets an internal register pointer. Each further byte is written to the pointed register, and the pointer then steps by one. In a read, bytes come from the pointer position, and the pointer steps after each byte. The pointer wraps within the register range.

Top module: `i2c_allcall_target`

## Requirements
- R1: SCL and SDA pass through two synchronising flops. SDA falling while SCL is high is a START, and a START at any point drops the byte in progress and begins a new address phase.
- R2: With `addr_sel`=0 the target acknowledges address 0x20. With `addr_sel`=1 it acknowledges 0x21. It NACKs every other address except the all-call address, and it ignores the rest of such a transfer.
- R3: The all-call address 0x68 with R/W=0 (address byte 0xD0) is acknowledged, and the bytes that follow are handled exactly like writes to the individual address.
- R4: A read to the all-call address (address byte 0xD1) is NACKed, and no read request is issued.
- R5: In a write, the first byte after the address loads the pointer. Each later byte gives a `wr_stb` pulse one clock wide, with `reg_ptr` and `wr_data` valid in that cycle. Every accepted byte is ACKed.
- R6: The pointer advances by one after each written or read data byte and wraps modulo 2^PTR_W (default 8 registers: 7 is followed by 0).
- R7: An accepted read address raises `rd_req` for one clock at the current pointer. The byte on `rd_data` two clocks after that pulse is shifted out MSB first. After each byte the master ACKs to ask for the next byte (a fresh `rd_req`) or NACKs to end the read.
- R8: SDA is driven only low, through `sda_oe`=1. The ACK is held over the ninth clock, and `sda_oe` changes only while the synchronised SCL is low.
- R9: While `rst_n` is low, `sda_oe`, `wr_stb` and `rd_req` are 0 and the pointer is 0. After reset the target waits for a START.
- R10: SDA rising while SCL is high is a STOP. A STOP ends the transfer and discards a partly received byte, so no write strobe is issued for it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than SCL |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Bus clock line as seen at the pad |
| sda_i | input | 1 | Bus data line as seen at the pad |
| addr_sel | input | 1 | Picks the individual address (0: 0x20, 1: 0x21) |
| sda_oe | output | 1 | 1 pulls SDA low; 0 releases it |
| reg_ptr | output | PTR_W | Register pointer for writes and reads |
| wr_stb | output | 1 | One-clock write strobe |
| wr_data | output | 8 | Write data, valid with `wr_stb` |
| rd_req | output | 1 | One-clock read request at `reg_ptr` |
| rd_data | input | 8 | Read byte from the register bank, sampled two clocks after `rd_req` |

## Verification
The bench targets the following corner cases:
- Pointer wrap from 7 to 0, both writing and reading. A design that got this wrong would write or return the wrong register.
- An all-call read. A design that got this wrong would ACK it and then fight other devices on SDA.
- Swapping `addr_sel`. A design that got this wrong would answer the stale address.
- Transfers cut short by a STOP or by a START in the middle of a data byte. A design that got this wrong would issue a write strobe from a partial shift register.
- A reset that lands while the ACK is driven. A design that got this wrong would leave SDA stuck low or keep the old pointer.

// File: rtl/i2c_allcall_target.sv
module i2c_allcall_target #(
  parameter int         PTR_W     = 3,
  parameter logic [6:0] ADDR_SEL0 = 7'h20,
  parameter logic [6:0] ADDR_SEL1 = 7'h21,
  parameter logic [6:0] ADDR_ALL  = 7'h68
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             scl_i,
  input  logic             sda_i,
  input  logic             addr_sel,
  output logic             sda_oe,
  output logic [PTR_W-1:0] reg_ptr,
  output logic             wr_stb,
  output logic [7:0]       wr_data,
  output logic             rd_req,
  input  logic [7:0]       rd_data
);

  typedef enum logic [2:0] {S_IDLE, S_RX, S_ACK, S_TX, S_MACK} state_t;
  typedef enum logic [1:0] {K_ADDR, K_PTR, K_DATA} kind_t;

  logic [1:0] scl_sy, sda_sy;
  logic       scl_q, sda_q;
  state_t     st;
  kind_t      kind;
  logic [3:0] cnt;
  logic [7:0] sr, txbuf;
  logic       rd_mode, rd_take;

  wire scl_s    = scl_sy[1];
  wire sda_s    = sda_sy[1];
  wire scl_rise = scl_s & ~scl_q;
  wire scl_fall = ~scl_s & scl_q;
  wire start_c  = scl_s & scl_q & sda_q & ~sda_s;
  wire stop_c   = scl_s & scl_q & ~sda_q & sda_s;

  wire [6:0] own_addr = addr_sel ? ADDR_SEL1 : ADDR_SEL0;
  wire hit_own = (sr[7:1] == own_addr);
  wire hit_all = (sr[7:1] == ADDR_ALL) && !sr[0];

  assign wr_data = sr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_sy  <= 2'b11;
      sda_sy  <= 2'b11;
      scl_q   <= 1'b1;
      sda_q   <= 1'b1;
      st      <= S_IDLE;
      kind    <= K_ADDR;
      cnt     <= '0;
      sr      <= '0;
      txbuf   <= '0;
      rd_mode <= 1'b0;
      rd_take <= 1'b0;
      sda_oe  <= 1'b0;
      reg_ptr <= '0;
      wr_stb  <= 1'b0;
      rd_req  <= 1'b0;
    end else begin
      scl_sy  <= {scl_sy[0], scl_i};
      sda_sy  <= {sda_sy[0], sda_i};
      scl_q   <= scl_s;
      sda_q   <= sda_s;
      wr_stb  <= 1'b0;
      rd_req  <= 1'b0;
      rd_take <= rd_req;
      if (rd_take) txbuf <= rd_data;

      if (start_c) begin
        st     <= S_RX;
        kind   <= K_ADDR;
        cnt    <= '0;
        sda_oe <= 1'b0;
      end else if (stop_c) begin
        st     <= S_IDLE;
        sda_oe <= 1'b0;
      end else begin
        case (st)
          S_RX: begin
            if (scl_rise && cnt != 4'd8) begin
              sr  <= {sr[6:0], sda_s};
              cnt <= cnt + 4'd1;
            end else if (scl_fall && cnt == 4'd8) begin
              st     <= S_ACK;
              sda_oe <= 1'b1;
              case (kind)
                K_ADDR: begin
                  if (hit_own || hit_all) begin
                    rd_mode <= sr[0];
                    rd_req  <= sr[0];
                  end else begin
                    st     <= S_IDLE;
                    sda_oe <= 1'b0;
                  end
                end
                K_PTR:   reg_ptr <= sr[PTR_W-1:0];
                default: wr_stb  <= 1'b1;
              endcase
            end
          end
          S_ACK: begin
            if (scl_fall) begin
              if (rd_mode && kind == K_ADDR) begin
                st     <= S_TX;
                sda_oe <= ~txbuf[7];
                sr     <= {txbuf[6:0], 1'b1};
                cnt    <= 4'd1;
              end else begin
                st     <= S_RX;
                sda_oe <= 1'b0;
                cnt    <= '0;
                kind   <= (kind == K_ADDR) ? K_PTR : K_DATA;
                if (kind == K_DATA) reg_ptr <= reg_ptr + 1'b1;
              end
            end
          end
          S_TX: begin
            if (scl_fall) begin
              if (cnt == 4'd8) begin
                st      <= S_MACK;
                sda_oe  <= 1'b0;
                reg_ptr <= reg_ptr + 1'b1;
              end else begin
                sda_oe <= ~sr[7];
                sr     <= {sr[6:0], 1'b1};
                cnt    <= cnt + 4'd1;
              end
            end
          end
          S_MACK: begin
            if (scl_rise) begin
              if (sda_s) st <= S_IDLE;
              else       rd_req <= 1'b1;
            end else if (scl_fall) begin
              st     <= S_TX;
              sda_oe <= ~txbuf[7];
              sr     <= {txbuf[6:0], 1'b1};
              cnt    <= 4'd1;
            end
          end
          default: ;
        endcase
      end
    end
  end

endmodule

module i2c_allcall_target_chk (
  input logic clk,
  input logic rst_n,
  input logic scl_s,
  input logic sda_oe,
  input logic wr_stb,
  input logic rd_req
);

  a_r8_oe_moves_on_scl_low: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(sda_oe) |-> !scl_s);

  a_r5_wr_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    wr_stb |=> !wr_stb);

  a_r7_rd_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    rd_req |=> !rd_req);

  a_r5_no_wr_rd_overlap: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_stb && rd_req));

  a_r9_reset_quiet: assert property (@(posedge clk)
    !rst_n |=> (!sda_oe && !wr_stb && !rd_req));

endmodule

bind i2c_allcall_target i2c_allcall_target_chk u_chk (
  .clk(clk), .rst_n(rst_n), .scl_s(scl_s),
  .sda_oe(sda_oe), .wr_stb(wr_stb), .rd_req(rd_req)
);

// File: tb/tb_i2c_allcall_target.sv
module tb_i2c_allcall_target;
  localparam int PTR_W = 3;
  localparam int NREG  = 1 << PTR_W;
  localparam int HP    = 40;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic scl_m = 1'b1, sda_m = 1'b1, addr_sel = 1'b0;
  logic sda_oe, wr_stb, rd_req;
  logic [PTR_W-1:0] reg_ptr;
  logic [7:0] wr_data, rd_data;
  wire sda_bus = sda_m & ~sda_oe;

  always #2 clk = ~clk;

  i2c_allcall_target #(.PTR_W(PTR_W)) dut (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(sda_bus),
    .addr_sel(addr_sel), .sda_oe(sda_oe), .reg_ptr(reg_ptr),
    .wr_stb(wr_stb), .wr_data(wr_data), .rd_req(rd_req), .rd_data(rd_data)
  );

  logic [7:0] bank [NREG];
  logic [7:0] exp_regs [NREG];
  int exp_q[$];
  int eptr = 0;
  int checks = 0, errors = 0;
  logic prev_oe = 1'b0;

  initial for (int i = 0; i < NREG; i++) begin bank[i] = 8'h00; exp_regs[i] = 8'h00; end

  always @(posedge clk) begin
    if (wr_stb) bank[reg_ptr] <= wr_data;
    if (rd_req) rd_data <= bank[reg_ptr];
  end

  task automatic chk(input bit ok, input string req, input int act, input int expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && wr_stb) begin
      if (exp_q.size() == 0) chk(1'b0, "R5 unexpected write strobe", {reg_ptr, wr_data}, 0);
      else begin
        int e;
        e = exp_q.pop_front();
        chk(int'({reg_ptr, wr_data}) == e, "R5 write strobe ptr/data", {reg_ptr, wr_data}, e);
      end
    end
    if (rst_n && sda_oe !== prev_oe && scl_m)
      chk(1'b0, "R8 sda_oe changed with SCL high", sda_oe, prev_oe);
    prev_oe = sda_oe;
  end

  task automatic hp(); repeat (HP) @(negedge clk); endtask
  task automatic qp(); repeat (HP/4) @(negedge clk); endtask

  task automatic do_start();
    sda_m = 1'b1; hp(); scl_m = 1'b1; hp(); sda_m = 1'b0; hp(); scl_m = 1'b0; qp();
  endtask

  task automatic do_stop();
    sda_m = 1'b0; hp(); scl_m = 1'b1; hp(); sda_m = 1'b1; hp();
  endtask

  task automatic clk_bit(input logic b, output logic r);
    sda_m = b; hp(); scl_m = 1'b1; qp(); r = sda_bus; hp(); scl_m = 1'b0; qp();
  endtask

  task automatic send_byte(input logic [7:0] d, output logic acked);
    logic r;
    for (int i = 7; i >= 0; i--) clk_bit(d[i], r);
    clk_bit(1'b1, r);
    acked = !r;
  endtask

  task automatic recv_byte(input logic last, output logic [7:0] d);
    logic r;
    for (int i = 7; i >= 0; i--) begin clk_bit(1'b1, r); d[i] = r; end
    clk_bit(last, r);
  endtask

  task automatic wr_txn(input logic [6:0] a, input logic exp_ack, input logic [7:0] p,
                        input int n, input logic [7:0] d [8], input bit no_stop, input string req);
    logic ack;
    do_start();
    send_byte({a, 1'b0}, ack);
    chk(ack == exp_ack, req, ack, exp_ack);
    if (ack) begin
      send_byte(p, ack);
      chk(ack, "R5 pointer byte ACK", ack, 1);
      eptr = p % NREG;
      for (int k = 0; k < n; k++) begin
        exp_q.push_back(eptr * 256 + d[k]);
        exp_regs[eptr] = d[k];
        eptr = (eptr + 1) % NREG;
        send_byte(d[k], ack);
        chk(ack, "R5 data byte ACK", ack, 1);
      end
    end
    if (!no_stop) do_stop();
  endtask

  task automatic rd_txn(input logic [6:0] a, input logic exp_ack, input int n, input string req);
    logic ack;
    logic [7:0] d;
    do_start();
    send_byte({a, 1'b1}, ack);
    chk(ack == exp_ack, req, ack, exp_ack);
    if (ack) begin
      for (int k = 0; k < n; k++) begin
        recv_byte(k == n - 1, d);
        chk(d == exp_regs[eptr], req, d, exp_regs[eptr]);
        eptr = (eptr + 1) % NREG;
      end
    end
    do_stop();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: run did not complete");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [7:0] d [8];
    logic r, ack;
    for (int i = 0; i < 8; i++) d[i] = 8'h00;
    repeat (5) @(negedge clk);
    chk(sda_oe == 0 && wr_stb == 0 && rd_req == 0, "R9 outputs quiet in reset", {sda_oe, wr_stb, rd_req}, 0);
    chk(reg_ptr == 0, "R9 pointer zero in reset", reg_ptr, 0);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);

    d[0] = 8'hA1; d[1] = 8'hB2; d[2] = 8'hC3;
    wr_txn(7'h20, 1'b1, 8'h02, 3, d, 1'b0, "R2 own address sel=0 ACK");
    wr_txn(7'h20, 1'b1, 8'h02, 0, d, 1'b1, "R2 own address before Sr");
    rd_txn(7'h20, 1'b1, 3, "R7 read after repeated START");

    addr_sel = 1'b1;
    wr_txn(7'h20, 1'b0, 8'h00, 0, d, 1'b0, "R2 old address NACK with sel=1");
    d[0] = 8'h11;
    wr_txn(7'h21, 1'b1, 8'h00, 1, d, 1'b0, "R2 address sel=1 ACK");

    d[0] = 8'h66; d[1] = 8'h77; d[2] = 8'h88; d[3] = 8'h99;
    wr_txn(7'h68, 1'b1, 8'h06, 4, d, 1'b0, "R3 all-call write ACK, R6 wrap");
    rd_txn(7'h68, 1'b0, 0, "R4 all-call read NACK");
    rd_txn(7'h21, 1'b1, 2, "R7 read from current pointer");
    wr_txn(7'h21, 1'b1, 8'h07, 0, d, 1'b1, "R6 set pointer 7");
    rd_txn(7'h21, 1'b1, 2, "R6 read wraps 7 to 0");

    wr_txn(7'h21, 1'b1, 8'h04, 0, d, 1'b1, "R10 pointer before abort");
    for (int i = 0; i < 4; i++) clk_bit(1'b0, r);
    do_stop();
    rd_txn(7'h21, 1'b1, 1, "R10 partial byte not written");

    do_start();
    send_byte({7'h21, 1'b0}, ack);
    send_byte(8'h01, ack);
    for (int i = 0; i < 5; i++) clk_bit(1'b1, r);
    d[0] = 8'h5A;
    wr_txn(7'h21, 1'b1, 8'h03, 1, d, 1'b0, "R1 START mid-byte restarts");
    wr_txn(7'h21, 1'b1, 8'h03, 0, d, 1'b1, "R1 pointer reload");
    rd_txn(7'h21, 1'b1, 1, "R1 only restarted write landed");

    do_start();
    for (int i = 7; i >= 1; i--) clk_bit(d[0][i] ^ d[0][i], r);
    begin
      logic [7:0] ab;
      ab = {7'h21, 1'b0};
      for (int i = 7; i >= 0; i--) ;
    end
    do_stop();
    do_start();
    begin
      logic [7:0] ab;
      ab = {7'h21, 1'b0};
      for (int i = 7; i >= 0; i--) clk_bit(ab[i], r);
    end
    chk(sda_oe == 1'b1, "R8 ACK driven after address", sda_oe, 1);
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    chk(sda_oe == 1'b0 && reg_ptr == 0, "R9 reset releases SDA and clears pointer", {sda_oe, reg_ptr}, 0);
    rst_n = 1'b1;
    do_stop();
    eptr = 0;
    rd_txn(7'h21, 1'b1, 1, "R9 read from pointer 0 after reset");

    repeat (10) @(negedge clk);
    chk(exp_q.size() == 0, "R5 all expected writes seen", exp_q.size(), 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule